// File: doc/BRIEF.md
# Compare-Value System Timer

The block holds two timer channels, physical and virtual, that watch a free-running 64-bit system count supplied from outside. Each channel stores an absolute 64-bit deadline and a small control word with an enable and a mask bit. Once the channel is enabled and its counter view has reached the deadline, a status condition becomes true. If the channel is not masked, a level interrupt request is raised and held for as long as that condition lasts.

Software can set the deadline in two ways. It can write the absolute compare value, or it can write a signed 32-bit relative delay that the block adds to the present count. Reading the relative view gives the remaining time, which turns negative once the deadline has passed. The physical channel compares against the count as given. The virtual channel compares against the count minus a 64-bit offset input. Both channels share one plain register port: a strobe, a write flag, an address and data, with read data returned one clock later.

Top module: `sys_timer_pair`

## Requirements
- R1: After reset, both control words and both compare registers are 0, both interrupt outputs are 0, and `rdata_o` is 0.
- R2: Control field layout: bit 0 is enable and bit 1 is mask. Bit 2 is a read-only status flag, and written values of bit 2 are ignored. Reads return the upper bits as 0.
- R3: Status reads 1 only when enable is 1 and the channel counter is at or above the compare value. The comparison is unsigned over all 64 bits, so a compare value of 2^63 is not reached by a counter of 1500.
- R4: Status reads 0 whenever enable is 0, whatever the counter and compare values are.
- R5: Each interrupt output is a registered level equal to enable AND NOT mask AND condition. It is evaluated at every clock edge from the counter sampled at that edge and the register values that the edge leaves. It therefore rises in the cycle after the edge at which the counter first reaches the compare value.
- R6: A compare write of a value that the counter has already passed, made while the channel is enabled and unmasked, sets the interrupt output directly after that write edge.
- R7: A control write with enable 0 clears the interrupt output directly after that write edge.
- R8: With enable and mask both 1 and the condition met, the interrupt output is 0 while status still reads 1.
- R9: A timer-value write loads compare with the counter plus the sign-extended low 32 bits of the write data. The upper 32 data bits are ignored.
- R10: A timer-value read returns the low 32 bits of (compare minus counter), sign-extended to 64 bits.
- R11: Address map: `addr_i[2]` selects the channel (0 physical, 1 virtual). `addr_i[1:0]` selects the register: 0 is control, 1 is compare, 2 is timer value, and 3 reads as 0 and ignores writes. The two channels keep separate state and drive separate outputs.
- R12: The virtual channel counter is `count_i - voff_i`, taken modulo 2^64. The physical channel uses `count_i`.
- R13: `rdata_o` is loaded at the clock edge that samples a read strobe (`req_i` high, `we_i` low) and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Free-running system count |
| voff_i | input | 64 | Offset subtracted for the virtual channel |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 3 | Channel and register select |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, one cycle after the read strobe |
| irq_phys_o | output | 1 | Physical channel interrupt level |
| irq_virt_o | output | 1 | Virtual channel interrupt level |

## Verification
The hardest case to reach is the masked state: the condition is met, status must read 1 and the output must stay low, and then the output must return as soon as the mask is cleared. The bench reaches it by stepping the count past the deadline with the channel enabled, then rewriting the control word with the mask and without it. It reads the control word in between. A second hard case is the unsigned-compare boundary: a deadline with bit 63 set that a signed comparison would treat as already passed. The bench writes such a deadline directly and confirms that no request appears. The virtual path is exercised with a nonzero offset, so that the physical and virtual channels see different counts at the same moment.

// File: rtl/sys_tmr_pkg.sv
package sys_tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_CMP  = 2'd1,
    REG_TVAL = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int CH_PHYS = 0;
  localparam int CH_VIRT = 1;

  typedef struct packed {
    logic mask;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import sys_tmr_pkg::*;
#(
  parameter int CW = 64,
  parameter int TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_ctl_i,
  input  logic          wr_cmp_i,
  input  logic          wr_tval_i,
  input  logic [CW-1:0] wdata_i,
  output logic [2:0]    ctl_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] tval_o,
  output logic          irq_o
);
  localparam int EW = CW - TW;

  ctl_t          ctl_q, ctl_d;
  logic [CW-1:0] cmp_q, cmp_d;
  logic [CW-1:0] tval_ext, diff;
  logic          irq_q, irq_d, status;

  assign tval_ext = {{EW{wdata_i[TW-1]}}, wdata_i[TW-1:0]};

  always_comb begin
    ctl_d = ctl_q;
    cmp_d = cmp_q;
    if (wr_ctl_i) ctl_d = '{mask: wdata_i[1], en: wdata_i[0]};
    if (wr_cmp_i)       cmp_d = wdata_i;
    else if (wr_tval_i) cmp_d = cnt_i + tval_ext;
    // evaluate with next-state so writes take effect at their own edge
    irq_d = ctl_d.en & ~ctl_d.mask & (cnt_i >= cmp_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      cmp_q <= cmp_d;
      irq_q <= irq_d;
    end
  end

  assign status = ctl_q.en & (cnt_i >= cmp_q);
  assign diff   = cmp_q - cnt_i;
  assign ctl_o  = {status, ctl_q.mask, ctl_q.en};
  assign cmp_o  = cmp_q;
  assign tval_o = {{EW{diff[TW-1]}}, diff[TW-1:0]};
  assign irq_o  = irq_q;

  p_irq_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl_q.en && !ctl_q.mask));
  p_no_early_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(cnt_i) >= cmp_q));
  p_ctl_zero_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl_i && !wdata_i[0]) |=> !irq_o);
  p_past_cmp_fires_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmp_i && !wr_ctl_i && ctl_q.en && !ctl_q.mask && (cnt_i >= wdata_i)) |=> irq_o);
  p_mask_silences_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.en && ctl_q.mask) |-> !irq_o);
  p_tval_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tval_i && !wr_cmp_i) |=> (cmp_q == $past(cnt_i + tval_ext)));
  p_status_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.en |-> !ctl_o[2]);
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import sys_tmr_pkg::*;
#(
  parameter int CW  = 64,
  parameter int NCH = 2,
  parameter int AW  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [NCH-1:0][2:0]     ctl_i,
  input  logic [NCH-1:0][CW-1:0]  cmp_i,
  input  logic [NCH-1:0][CW-1:0]  tval_i,
  output logic [NCH-1:0]          wr_ctl_o,
  output logic [NCH-1:0]          wr_cmp_o,
  output logic [NCH-1:0]          wr_tval_o,
  output logic [CW-1:0]           rdata_o
);
  localparam int SW = 2;
  localparam int IW = AW - SW;

  reg_sel_e      sel;
  logic [IW-1:0] ch;
  logic          ch_ok;
  logic [CW-1:0] rdata_q, rd_mux;

  assign sel   = reg_sel_e'(addr_i[SW-1:0]);
  assign ch    = addr_i[AW-1:SW];
  assign ch_ok = (int'(ch) < NCH);

  for (genvar g = 0; g < NCH; g++) begin : g_wr
    logic hit;
    assign hit          = req_i && we_i && (int'(ch) == g);
    assign wr_ctl_o[g]  = hit && (sel == REG_CTL);
    assign wr_cmp_o[g]  = hit && (sel == REG_CMP);
    assign wr_tval_o[g] = hit && (sel == REG_TVAL);
  end

  always_comb begin
    rd_mux = '0;
    if (ch_ok) begin
      unique case (sel)
        REG_CTL:  rd_mux = {{(CW-3){1'b0}}, ctl_i[ch]};
        REG_CMP:  rd_mux = cmp_i[ch];
        REG_TVAL: rd_mux = tval_i[ch];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_rd_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  p_one_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ctl_o, wr_cmp_o, wr_tval_o}));
endmodule

// File: rtl/sys_timer_pair.sv
module sys_timer_pair
  import sys_tmr_pkg::*;
#(
  parameter int CW = 64,
  parameter int TW = 32,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] voff_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          irq_phys_o,
  output logic          irq_virt_o
);
  localparam int NCH = 2;

  logic [NCH-1:0][2:0]    ctl;
  logic [NCH-1:0][CW-1:0] cmp, tval, eff_cnt;
  logic [NCH-1:0]         wr_ctl, wr_cmp, wr_tval, irq;

  tmr_regif #(.CW(CW), .NCH(NCH), .AW(AW)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .ctl_i(ctl), .cmp_i(cmp), .tval_i(tval),
    .wr_ctl_o(wr_ctl), .wr_cmp_o(wr_cmp), .wr_tval_o(wr_tval),
    .rdata_o
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == CH_VIRT) begin : g_virt
      assign eff_cnt[g] = count_i - voff_i;
    end else begin : g_phys
      assign eff_cnt[g] = count_i;
    end

    tmr_channel #(.CW(CW), .TW(TW)) u_ch (
      .clk_i, .rst_ni,
      .cnt_i(eff_cnt[g]),
      .wr_ctl_i(wr_ctl[g]), .wr_cmp_i(wr_cmp[g]), .wr_tval_i(wr_tval[g]),
      .wdata_i,
      .ctl_o(ctl[g]), .cmp_o(cmp[g]), .tval_o(tval[g]), .irq_o(irq[g])
    );
  end

  assign irq_phys_o = irq[CH_PHYS];
  assign irq_virt_o = irq[CH_VIRT];
endmodule

// File: tb/tb_sys_timer_pair.sv
module tb_sys_timer_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0, voff = '0, wdata = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [63:0] rdata;
  logic        irq_p, irq_v;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_timer_pair dut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .voff_i(voff),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_phys_o(irq_p), .irq_virt_o(irq_v)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) begin
    if (rst_n && req && !we) begin
      #1;
      if (sb_q.size() == 0) check("R13 unexpected read", rdata, '0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [63:0] e, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    sb_q.push_back('{exp: e, tag: tag});
    @(posedge clk); #2;
    req = 0;
  endtask

  task automatic set_cnt(logic [63:0] c);
    @(negedge clk);
    count = c;
    @(posedge clk); #2;
  endtask

  // addresses: [2]=channel, [1:0]=ctl/cmp/tval/rsvd
  localparam logic [2:0] P_CTL = 3'd0, P_CMP = 3'd1, P_TV = 3'd2, P_RS = 3'd3;
  localparam logic [2:0] V_CTL = 3'd4, V_CMP = 3'd5, V_TV = 3'd6;

  initial begin
    logic [63:0] held;
    repeat (3) @(posedge clk);
    #2 check("R1 irq_phys reset", irq_p, 0);
    check("R1 irq_virt reset", irq_v, 0);
    check("R1 rdata reset", rdata, 0);
    @(negedge clk) rst_n = 1;
    rd(P_CTL, 0, "R1 phys ctl");
    rd(P_CMP, 0, "R1 phys cmp");
    rd(V_CTL, 0, "R1 virt ctl");

    set_cnt(1000);
    wr(P_CMP, 1500);
    wr(P_CTL, 1);
    check("R3 no irq before deadline", irq_p, 0);
    rd(P_CTL, 1, "R3 status 0 before deadline");
    rd(P_TV, 500, "R10 tval positive");
    set_cnt(1499);
    check("R3 no irq at cmp-1", irq_p, 0);
    set_cnt(1500);
    check("R5 irq at deadline", irq_p, 1);
    rd(P_CTL, 5, "R3 status at deadline");
    check("R11 virt unaffected", irq_v, 0);

    wr(P_CTL, 3);
    check("R8 mask silences irq", irq_p, 0);
    rd(P_CTL, 7, "R8 status kept under mask");
    wr(P_CTL, 5);
    check("R2 bit2 write ignored, irq back", irq_p, 1);
    rd(P_CTL, 5, "R2 ctl readback");
    wr(P_CTL, 0);
    check("R7 ctl zero drops irq", irq_p, 0);
    rd(P_CTL, 0, "R4 status 0 when disabled");
    wr(P_CTL, 4);
    rd(P_CTL, 0, "R2 status not writable");

    wr(P_CMP, 5000);
    wr(P_CTL, 1);
    check("R6 future cmp no irq", irq_p, 0);
    wr(P_CMP, 100);
    check("R6 past cmp fires at once", irq_p, 1);
    wr(P_CMP, 2000);
    check("R3 future cmp clears", irq_p, 0);

    wr(P_TV, 64'h1234_5678_FFFF_FFCE);
    check("R9 negative tval fires", irq_p, 1);
    rd(P_CMP, 1450, "R9 tval loads cnt+sext");
    rd(P_TV, 64'hFFFF_FFFF_FFFF_FFCE, "R10 tval negative after expiry");

    wr(P_CMP, 64'h8000_0000_0000_0000);
    check("R3 unsigned compare no irq", irq_p, 0);
    rd(P_CTL, 1, "R3 unsigned status 0");

    @(negedge clk) voff = 1000;
    wr(V_CMP, 600);
    wr(V_CTL, 1);
    check("R12 virt before deadline", irq_v, 0);
    rd(V_TV, 100, "R12 virt tval uses offset");
    set_cnt(1600);
    check("R12 virt fires at cnt-off", irq_v, 1);
    check("R11 phys independent", irq_p, 0);
    rd(V_CTL, 5, "R11 virt ctl");
    rd(P_CTL, 1, "R11 phys ctl separate");
    wr(P_RS, 64'hFFFF);
    rd(P_RS, 0, "R11 reserved reads zero");
    rd(P_CMP, 64'h8000_0000_0000_0000, "R11 reserved write ignored");

    held = 64'h8000_0000_0000_0000;
    wr(P_CMP, 7);
    repeat (3) @(posedge clk);
    #2 check("R13 rdata holds without read", rdata, held);

    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule